// File: doc/BRIEF.md
# Voltage Converter Control and Status Register Front End

This block puts a 12-bit voltage analog-to-digital converter on a byte-wide register bus. Three byte registers are visible: a control and status register that holds the converter enable, the start/busy bit, the completion flag and the completion interrupt enable, and two read-only bytes that return the latest result. Software starts a conversion by writing the control register. The block then sends a one-cycle request to the external converter and waits for its done pulse.

On an accepted done pulse the block stores the converter's 12-bit sample, clears busy and raises the completion flag. The interrupt request follows the flag, the local interrupt enable and a global interrupt enable input. The flag can be cleared by software writing a one to it, or by an acknowledge pulse when the interrupt vector is taken. Clearing the enable bit aborts a conversion in progress, and a done pulse that arrives later is discarded.

Bus reads are registered. `bus_rdata` shows the register selected by `bus_addr` at a clock edge, as it stood before that edge, and it holds that value until the next edge.

Top module: `vconv_regif`

## Requirements
- R1: After synchronous reset, all three registers read zero, and `conv_req` and `irq` are low.
- R2: The control and status register is at address 2. Bit 0 is the interrupt enable, bit 1 the completion flag, bit 2 start/busy and bit 3 the enable. Bits 7:4 read zero. `bus_rdata` gives the selected register one clock after the address is presented.
- R3: A control write with bit 3 and bit 2 both one, while no conversion is busy, produces a `conv_req` pulse exactly one cycle wide at the next clock edge. A write with bit 2 zero, or with bit 3 zero, starts nothing.
- R4: The start/busy bit reads one from the start until an accepted done pulse, and reads zero afterwards.
- R5: A start write made while a conversion is busy is ignored and produces no new `conv_req`.
- R6: A control write with bit 3 zero clears busy at once. A done pulse while not busy is discarded, and both the result and the flag stay unchanged.
- R7: An accepted done pulse loads `conv_data` into the result and sets the completion flag on the same clock edge.
- R8: Address 0 returns result bits 7:0. Address 1 returns result bits 11:8 in its low nibble, and its upper nibble reads zero.
- R9: The flag is cleared by a control write with bit 1 at one, or by `irq_ack`. A write with bit 1 at zero leaves the flag as it is. This means a read-modify-write of a set flag clears it.
- R10: When a completion and a flag clear fall in the same cycle, the completion wins and the flag stays set.
- R11: `irq` is high exactly when the flag, the interrupt enable bit and `glob_ie` are all one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select (0 result low, 1 result high, 2 control/status) |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| glob_ie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge pulse, clears the flag |
| conv_req | output | 1 | One-cycle conversion request to the converter |
| conv_done | input | 1 | Converter completion pulse |
| conv_data | input | 12 | Converter sample, valid with `conv_done` |
| irq | output | 1 | Completion interrupt request |

## Verification
The bench targets the races around the flag. It drives a software clear and a completion in the same cycle, and a design that lets the clear win would lose that interrupt. It also shows that writing back a set flag as a one clears it. It aborts a busy conversion and then delivers a late done pulse: a design that still accepts that pulse would overwrite the result or raise a false flag. It repeats a start while busy and writes start with enable low, where a wrong design emits an extra request or starts while disabled. A design that leaks result bits into the upper nibble of the high byte is also caught.

// File: rtl/vconv_pkg.sv
package vconv_pkg;
  // Control/status bit positions (software decodes these)
  localparam int CSR_IE    = 0;
  localparam int CSR_FLAG  = 1;
  localparam int CSR_START = 2;
  localparam int CSR_EN    = 3;

  typedef enum logic [1:0] {
    SEL_RES_LO = 2'd0,
    SEL_RES_HI = 2'd1,
    SEL_CSR    = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/vconv_ctrl.sv
module vconv_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic csr_wr,
  input  logic wr_en_bit,
  input  logic wr_start_bit,
  input  logic wr_ie_bit,
  input  logic conv_done,
  output logic en,
  output logic ie,
  output logic busy,
  output logic conv_req,
  output logic done_ok
);
  logic start_ok;
  logic abort;

  always_comb begin
    start_ok = csr_wr && wr_en_bit && wr_start_bit && !busy;
    abort    = csr_wr && !wr_en_bit;
    done_ok  = conv_done && busy && !abort;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en       <= 1'b0;
      ie       <= 1'b0;
      busy     <= 1'b0;
      conv_req <= 1'b0;
    end else begin
      conv_req <= start_ok;
      if (csr_wr) begin
        en <= wr_en_bit;
        ie <= wr_ie_bit;
      end
      if (abort)         busy <= 1'b0;
      else if (start_ok) busy <= 1'b1;
      else if (done_ok)  busy <= 1'b0;
    end
  end

  assert_req_single_R3: assert property (@(posedge clk) disable iff (rst)
    conv_req |=> !conv_req);
  assert_busy_rise_req_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> conv_req);
  assert_no_restart_R5: assert property (@(posedge clk) disable iff (rst)
    (busy && csr_wr && wr_start_bit) |=> !conv_req);
  assert_abort_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (csr_wr && !wr_en_bit) |=> (!busy && !en));
  assert_done_idle_R4: assert property (@(posedge clk) disable iff (rst)
    done_ok |=> !busy);
endmodule

// File: rtl/vconv_status.sv
module vconv_status #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             done_ok,
  input  logic [RES_W-1:0] conv_data,
  input  logic             clr_wr,
  input  logic             irq_ack,
  output logic             flag,
  output logic [RES_W-1:0] result
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag   <= 1'b0;
      result <= '0;
    end else if (done_ok) begin
      result <= conv_data;
      flag   <= 1'b1;
    end else if (clr_wr || irq_ack) begin
      flag   <= 1'b0;
    end
  end

  assert_capture_R7: assert property (@(posedge clk) disable iff (rst)
    done_ok |=> (flag && result == $past(conv_data)));
  assert_flag_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (!done_ok && (clr_wr || irq_ack)) |=> !flag);
  assert_done_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (done_ok && (clr_wr || irq_ack)) |=> flag);
  assert_result_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !done_ok |=> $stable(result));
endmodule

// File: rtl/vconv_regif.sv
module vconv_regif
  import vconv_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RES_W  = 12,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              glob_ie,
  input  logic              irq_ack,
  output logic              conv_req,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_data,
  output logic              irq
);
  localparam int HI_W  = RES_W - DATA_W;
  localparam int PAD_W = DATA_W - HI_W;

  logic             csr_wr;
  logic             en, ie, busy, flag, done_ok;
  logic [RES_W-1:0] result;
  logic [DATA_W-1:0] rd_lo, rd_hi, rd_csr;

  assign csr_wr = bus_wr && (bus_addr == ADDR_W'(SEL_CSR));

  vconv_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .csr_wr       (csr_wr),
    .wr_en_bit    (bus_wdata[CSR_EN]),
    .wr_start_bit (bus_wdata[CSR_START]),
    .wr_ie_bit    (bus_wdata[CSR_IE]),
    .conv_done    (conv_done),
    .en           (en),
    .ie           (ie),
    .busy         (busy),
    .conv_req     (conv_req),
    .done_ok      (done_ok)
  );

  vconv_status #(.RES_W(RES_W)) u_status (
    .clk       (clk),
    .rst       (rst),
    .done_ok   (done_ok),
    .conv_data (conv_data),
    .clr_wr    (csr_wr && bus_wdata[CSR_FLAG]),
    .irq_ack   (irq_ack),
    .flag      (flag),
    .result    (result)
  );

  assign rd_lo = result[DATA_W-1:0];

  generate
    if (PAD_W > 0) begin : g_hi_pad
      assign rd_hi = {{PAD_W{1'b0}}, result[RES_W-1:DATA_W]};
    end else begin : g_hi_full
      assign rd_hi = result[RES_W-1:DATA_W];
    end
  endgenerate

  always_comb begin
    rd_csr            = '0;
    rd_csr[CSR_IE]    = ie;
    rd_csr[CSR_FLAG]  = flag;
    rd_csr[CSR_START] = busy;
    rd_csr[CSR_EN]    = en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      unique case (bus_addr)
        ADDR_W'(SEL_RES_LO): bus_rdata <= rd_lo;
        ADDR_W'(SEL_RES_HI): bus_rdata <= rd_hi;
        ADDR_W'(SEL_CSR):    bus_rdata <= rd_csr;
        default:             bus_rdata <= '0;
      endcase
    end
  end

  assign irq = flag && ie && glob_ie;

  assert_hi_pad_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(SEL_RES_HI)) |=> (bus_rdata[DATA_W-1:HI_W] == '0));
  assert_csr_pad_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == ADDR_W'(SEL_CSR)) |=> (bus_rdata[DATA_W-1:CSR_EN+1] == '0));
  assert_irq_gate_R11: assert property (@(posedge clk) disable iff (rst)
    irq |-> (glob_ie && $countones({flag, ie}) == 2));
endmodule

// File: tb/test_vconv_regif.sv
module test_vconv_regif;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        glob_ie = 1'b0;
  logic        irq_ack = 1'b0;
  logic        conv_req;
  logic        conv_done = 1'b0;
  logic [11:0] conv_data = '0;
  logic        irq;

  int tests = 0;
  int fails = 0;
  logic [11:0] exp_q[$];

  always #5 clk = ~clk;

  vconv_regif i_vconv_regif (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .glob_ie(glob_ie),
    .irq_ack(irq_ack), .conv_req(conv_req), .conv_done(conv_done),
    .conv_data(conv_data), .irq(irq)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic wr(input logic [7:0] d);
    bus_addr = 2'd2; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    @(posedge clk); @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic done_pulse(input logic [11:0] d);
    conv_data = d; conv_done = 1'b1;
    @(posedge clk); @(negedge clk);
    conv_done = 1'b0;
  endtask

  // Monitor side of the scoreboard: pop the expected sample and compare both bytes.
  task automatic check_result(input string tag);
    logic [7:0] lo, hi;
    logic [11:0] e;
    e = exp_q.pop_front();
    rd(2'd0, lo);
    rd(2'd1, hi);
    check({tag, " low byte"}, {8'h0, lo}, {8'h0, e[7:0]});
    check({tag, " high byte"}, {8'h0, hi}, {12'h0, e[11:8]});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 conv_req", {15'h0, conv_req}, 16'h0);
    check("R1 irq", {15'h0, irq}, 16'h0);
    rd(2'd0, v); check("R1 result low", {8'h0, v}, 16'h0);
    rd(2'd1, v); check("R1 result high", {8'h0, v}, 16'h0);
    rd(2'd2, v); check("R1 csr", {8'h0, v}, 16'h0);

    // R3 start with enable low does nothing
    wr(8'h04);
    check("R3 no req when disabled", {15'h0, conv_req}, 16'h0);
    // R2 enable readback
    wr(8'h08);
    rd(2'd2, v); check("R2 csr enable", {8'h0, v}, 16'h08);

    // R3 start pulse
    wr(8'h0C);
    check("R3 req pulse", {15'h0, conv_req}, 16'h1);
    @(negedge clk);
    check("R3 req one cycle", {15'h0, conv_req}, 16'h0);
    rd(2'd2, v); check("R4 busy set", {8'h0, v}, 16'h0C);
    // R5 start while busy
    wr(8'h0C);
    check("R5 no restart", {15'h0, conv_req}, 16'h0);
    // R3 writing start zero has no effect
    wr(8'h08);
    rd(2'd2, v); check("R3 zero start no effect", {8'h0, v}, 16'h0C);

    // R7 completion
    exp_q.push_back(12'hA5C);
    done_pulse(12'hA5C);
    rd(2'd2, v); check("R7 flag set busy clear R4", {8'h0, v}, 16'h0A);
    check_result("R8 result A5C");

    // R11 irq gating, R9 write zero to flag keeps it
    check("R11 irq off with ie low", {15'h0, irq}, 16'h0);
    wr(8'h09);
    check("R11 irq off with glob low", {15'h0, irq}, 16'h0);
    rd(2'd2, v); check("R9 zero write keeps flag", {8'h0, v}, 16'h0B);
    glob_ie = 1'b1;
    #1 check("R11 irq on", {15'h0, irq}, 16'h1);
    // R9 acknowledge clears
    irq_ack = 1'b1; @(posedge clk); @(negedge clk); irq_ack = 1'b0;
    check("R9 ack clears irq", {15'h0, irq}, 16'h0);
    rd(2'd2, v); check("R9 ack clears flag", {8'h0, v}, 16'h09);

    // second conversion, R9 read-modify-write clears the flag
    wr(8'h0D);
    exp_q.push_back(12'h3F1);
    done_pulse(12'h3F1);
    check("R11 irq after done", {15'h0, irq}, 16'h1);
    rd(2'd2, v);
    wr(v);
    rd(2'd2, v); check("R9 rmw clears flag", {8'h0, v}, 16'h09);
    check_result("R8 result 3F1");

    // R10 clear and completion in the same cycle
    wr(8'h0D);
    exp_q.push_back(12'h7E4);
    bus_addr = 2'd2; bus_wdata = 8'h0B; bus_wr = 1'b1;
    conv_data = 12'h7E4; conv_done = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; conv_done = 1'b0;
    rd(2'd2, v); check("R10 completion wins", {8'h0, v}, 16'h0B);
    check("R10 irq held", {15'h0, irq}, 16'h1);
    check_result("R10 result 7E4");

    // R6 abort and late done
    wr(8'h0B);
    wr(8'h0D);
    wr(8'h00);
    rd(2'd2, v); check("R6 abort clears busy", {8'h0, v}, 16'h00);
    done_pulse(12'h123);
    rd(2'd2, v); check("R6 late done no flag", {8'h0, v}, 16'h00);
    exp_q.push_back(12'h7E4);
    check_result("R6 result unchanged");
    check("R6 no irq", {15'h0, irq}, 16'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule